// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a NOR-style flash that has several banks working independently of each other. It watches the host bus write strobes (write enable and chip enable, both active low) and forms one write event from each strobe pair. Each write is routed to a bank by the upper address bits. A separate mode machine in each bank interprets the write sequences. The machine decides whether the bank reads its array or serves identification data, whether it is collecting a program or erase sequence, waiting on the embedded engine, holding an erase in suspension, or stuck in an error or invalid state.

A behavioural program/erase engine sits beside the block. The block starts it with a one-cycle start pulse and an operation code, and takes back per-bank done and error pulses. The read path uses the per-bank mode code and a combinational flag that marks a read address as invalid. A read is invalid when it falls in the sector, or the whole bank, whose erase is currently suspended.

The command set, with word addresses taken from the low 11 bits of the bank offset, is as follows. 0xF0 is the reset command. The two key cycles are 0xAA at 0x555 and then 0x55 at 0x2AA. The third cycle at 0x555 selects the operation: 0x90 for identification, 0xA0 for program, 0x80 for erase. An erase then needs the two key cycles again. After them, 0x30 erases one sector, or 0x10 at 0x555 erases the whole bank. 0xB0 suspends a running erase, and 0x30 resumes it.

Top module: `fcmd_iface`

## Requirements
- R1: After reset, every bank reports mode code 0 (read array). Every errFlag bit is 0 and no engStart pulse is issued.
- R2: A write takes its address at the later falling edge of weN/ceN, meaning the cycle in which both are first seen low. It takes its data at the earlier rising edge, meaning the first cycle in which either is seen high again. Address or data changes outside those points have no effect.
- R3: The key cycles followed by 0x90 at 0x555 put the bank in identification mode (code 2). Any write other than 0xF0 leaves it there, and 0xF0 returns it to code 0.
- R4: The key cycles followed by 0xA0 at 0x555 give code 3. The next write moves the bank to busy-program (code 5) and pulses engStart with engOp 0. An engDone pulse then returns the bank to code 0.
- R5: The key cycles, then 0x80 at 0x555 (code 4), then the key cycles again, then a final write complete the erase sequence. A final 0x30 at any address gives busy-erase (code 6) with engOp 1 and records the sector (offset bits [14:12] at default parameters). A final 0x10 at 0x555 gives code 6 with engOp 2, which erases the whole bank.
- R6: 0xF0 written at any address between the cycles of a sequence aborts the sequence. The bank returns to code 0 if it was not erase-suspended.
- R7: In busy-program or busy-erase, 0xF0 and any other write are ignored, except 0xB0 during busy-erase. The mode changes only on engDone or engErr.
- R8: 0xB0 in busy-erase gives erase-suspend-read (code 1). While suspended, rdInvalid is 1 only for read addresses in that bank that lie in the suspended sector, or anywhere in the bank after a whole-bank erase. 0x30 resumes the erase, giving code 6 and an engStart pulse with engOp 3.
- R9: A suspended bank keeps its suspension through other operations. A program completed from suspension, a reset written inside a sequence started there, and a reset out of identification entered from there all return the bank to code 1.
- R10: engErr during busy-program or busy-erase gives the error state (code 7) with errFlag set. Writes other than 0xF0 are ignored there. 0xF0 returns the bank to code 0, or to code 1 if it was suspended, and clears errFlag.
- R11: A wrong key address or data, or a command out of sequence, puts the bank in the invalid state (code 8). Out-of-sequence commands include 0xB0 outside an erase and 0x80 while suspended. Only 0xF0 leaves the invalid state.
- R12: Writes act only on the bank selected by the top address bit (at default parameters). One bank may be busy or mid-sequence while another decodes commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on it |
| rstN | input | 1 | Asynchronous active-low reset |
| weN | input | 1 | Host write enable, active low |
| ceN | input | 1 | Host chip enable, active low |
| addr | input | ADDR_W | Host word address; top bits select the bank |
| data | input | 8 | Host command data |
| engDone | input | NUM_BANKS | Engine finished the operation of a bank (pulse) |
| engErr | input | NUM_BANKS | Engine failed the operation of a bank (pulse) |
| engStart | output | NUM_BANKS | Start pulse to the engine, per bank |
| engOp | output | 2*NUM_BANKS | Operation per bank: 0 program, 1 sector erase, 2 bank erase, 3 resume |
| bankMode | output | 4*NUM_BANKS | Mode code per bank, codes 0 to 8 as in the requirements |
| errFlag | output | NUM_BANKS | Per-bank error flag |
| rdAddr | input | ADDR_W | Read path address under test |
| rdInvalid | output | 1 | Read at rdAddr hits a suspended erase region |

## Verification
A wrong internal state shows on bankMode two clock cycles after the strobe that ends the offending write. It does not wait until a later read goes astray. A missed transition also leaves the next command of a sequence landing in the invalid code (8). A lost suspended-sector record shows at once on rdInvalid for the next read address presented. A wrong reset target shows as code 0 where code 1 is due. A bank that leaks into a neighbour shows as a mode change on a bank that was never addressed.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int KEY_W = 11;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 11'h2AA;

  typedef enum logic [3:0] {
    K_RESET, K_KEY1, K_KEY2, K_AUTO, K_PROG, K_ERASE,
    K_SECTOR, K_WHOLE, K_SUSPEND, K_OTHER
  } cmdKind_t;

  // strobe bundle from the bus capture datapath to the control
  typedef struct packed {
    logic     valid;
    cmdKind_t kind;
    logic     atKeyA;
    logic     atKeyB;
  } hostWrite_t;

  typedef enum logic [3:0] {
    S_READ, S_SREAD, S_AUTO, S_KEY1, S_KEY2, S_PDATA,
    S_EKEY0, S_EKEY1, S_EKEY2, S_BPROG, S_BERASE, S_ERROR, S_INVAL
  } bankState_t;

  localparam logic [3:0] MODE_READ   = 4'd0;
  localparam logic [3:0] MODE_SREAD  = 4'd1;
  localparam logic [3:0] MODE_AUTO   = 4'd2;
  localparam logic [3:0] MODE_CMDSEQ = 4'd3;
  localparam logic [3:0] MODE_ERSEQ  = 4'd4;
  localparam logic [3:0] MODE_BPROG  = 4'd5;
  localparam logic [3:0] MODE_BERASE = 4'd6;
  localparam logic [3:0] MODE_ERROR  = 4'd7;
  localparam logic [3:0] MODE_INVAL  = 4'd8;

  localparam logic [1:0] OP_PROG   = 2'd0;
  localparam logic [1:0] OP_SECTOR = 2'd1;
  localparam logic [1:0] OP_BANK   = 2'd2;
  localparam logic [1:0] OP_RESUME = 2'd3;

  function automatic cmdKind_t decodeCmd(input logic [7:0] d);
    case (d)
      8'hF0:   return K_RESET;
      8'hAA:   return K_KEY1;
      8'h55:   return K_KEY2;
      8'h90:   return K_AUTO;
      8'hA0:   return K_PROG;
      8'h80:   return K_ERASE;
      8'h30:   return K_SECTOR;
      8'h10:   return K_WHOLE;
      8'hB0:   return K_SUSPEND;
      default: return K_OTHER;
    endcase
  endfunction

  function automatic logic [3:0] modeOf(input bankState_t s);
    case (s)
      S_READ:                  return MODE_READ;
      S_SREAD:                 return MODE_SREAD;
      S_AUTO:                  return MODE_AUTO;
      S_KEY1, S_KEY2, S_PDATA: return MODE_CMDSEQ;
      S_EKEY0, S_EKEY1,
      S_EKEY2:                 return MODE_ERSEQ;
      S_BPROG:                 return MODE_BPROG;
      S_BERASE:                return MODE_BERASE;
      S_ERROR:                 return MODE_ERROR;
      default:                 return MODE_INVAL;
    endcase
  endfunction

endpackage

// File: rtl/fcmd_bus_capture.sv
module fcmd_bus_capture
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weN,
  input  logic              ceN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output hostWrite_t        wrOut,
  output logic [ADDR_W-1:0] wrAddr
);

  logic              weQ, ceQ, actD;
  logic [ADDR_W-1:0] addrQ, latAddr;
  logic [7:0]        dataQ;
  logic              actNow;

  assign actNow = !weQ && !ceQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ     <= 1'b1;
      ceQ     <= 1'b1;
      actD    <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      latAddr <= '0;
      wrAddr  <= '0;
      wrOut   <= '{valid: 1'b0, kind: K_OTHER, atKeyA: 1'b0, atKeyB: 1'b0};
    end else begin
      weQ   <= weN;
      ceQ   <= ceN;
      addrQ <= addr;
      dataQ <= data;
      actD  <= actNow;
      // both strobes low for the first time: address point
      if (actNow && !actD) latAddr <= addrQ;
      // first strobe back high: data point, write event
      wrOut.valid <= actD && !actNow;
      if (actD && !actNow) begin
        wrOut.kind   <= decodeCmd(dataQ);
        wrOut.atKeyA <= (latAddr[KEY_W-1:0] == KEY_ADDR_A);
        wrOut.atKeyB <= (latAddr[KEY_W-1:0] == KEY_ADDR_B);
        wrAddr       <= latAddr;
      end
    end
  end

endmodule

// File: rtl/fcmd_bank_fsm.sv
module fcmd_bank_fsm
  import fcmd_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostWrite_t        wr,
  input  logic              hit,
  input  logic [SECT_W-1:0] wrSector,
  input  logic              engDone,
  input  logic              engErr,
  output bankState_t        state,
  output logic              engStart,
  output logic [1:0]        engOp,
  output logic [SECT_W-1:0] suspSector,
  output logic              suspWhole
);

  bankState_t        stNext;
  logic              susp, suspNext, startNext, wholeNext, secLoad;
  logic [1:0]        opNext;
  bankState_t        homeSt;

  assign homeSt = susp ? S_SREAD : S_READ;

  always_comb begin
    stNext    = state;
    suspNext  = susp;
    startNext = 1'b0;
    opNext    = engOp;
    wholeNext = suspWhole;
    secLoad   = 1'b0;
    case (state)
      S_BPROG: begin
        if (engErr)       stNext = S_ERROR;
        else if (engDone) stNext = homeSt;
      end
      S_BERASE: begin
        if (engErr)       stNext = S_ERROR;
        else if (engDone) stNext = S_READ;
        else if (hit && wr.kind == K_SUSPEND) begin
          stNext   = S_SREAD;
          suspNext = 1'b1;
        end
      end
      default: begin
        if (hit) begin
          if (wr.kind == K_RESET) stNext = homeSt;
          else begin
            case (state)
              S_READ:
                stNext = (wr.kind == K_KEY1 && wr.atKeyA) ? S_KEY1 : S_INVAL;
              S_SREAD: begin
                if (wr.kind == K_KEY1 && wr.atKeyA) stNext = S_KEY1;
                else if (wr.kind == K_SECTOR) begin
                  stNext    = S_BERASE;
                  suspNext  = 1'b0;
                  startNext = 1'b1;
                  opNext    = OP_RESUME;
                end else if (wr.kind != K_SUSPEND) stNext = S_INVAL;
              end
              S_KEY1:
                stNext = (wr.kind == K_KEY2 && wr.atKeyB) ? S_KEY2 : S_INVAL;
              S_KEY2: begin
                stNext = S_INVAL;
                if (wr.atKeyA) begin
                  if (wr.kind == K_AUTO) stNext = S_AUTO;
                  else if (wr.kind == K_PROG) stNext = S_PDATA;
                  else if (wr.kind == K_ERASE && !susp) stNext = S_EKEY0;
                end
              end
              S_PDATA: begin
                stNext    = S_BPROG;
                startNext = 1'b1;
                opNext    = OP_PROG;
              end
              S_EKEY0:
                stNext = (wr.kind == K_KEY1 && wr.atKeyA) ? S_EKEY1 : S_INVAL;
              S_EKEY1:
                stNext = (wr.kind == K_KEY2 && wr.atKeyB) ? S_EKEY2 : S_INVAL;
              S_EKEY2: begin
                if (wr.kind == K_SECTOR) begin
                  stNext    = S_BERASE;
                  startNext = 1'b1;
                  opNext    = OP_SECTOR;
                  wholeNext = 1'b0;
                  secLoad   = 1'b1;
                end else if (wr.kind == K_WHOLE && wr.atKeyA) begin
                  stNext    = S_BERASE;
                  startNext = 1'b1;
                  opNext    = OP_BANK;
                  wholeNext = 1'b1;
                end else stNext = S_INVAL;
              end
              default: stNext = state;  // identification, error, invalid
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_READ;
      susp       <= 1'b0;
      engStart   <= 1'b0;
      engOp      <= OP_PROG;
      suspWhole  <= 1'b0;
      suspSector <= '0;
    end else begin
      state     <= stNext;
      susp      <= suspNext;
      engStart  <= startNext;
      engOp     <= opNext;
      suspWhole <= wholeNext;
      if (secLoad) suspSector <= wrSector;
    end
  end

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hostWrite_t             wr,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [NUM_BANKS-1:0]   engDone,
  input  logic [NUM_BANKS-1:0]   engErr,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [NUM_BANKS-1:0]   engStart,
  output logic [2*NUM_BANKS-1:0] engOp,
  output logic [4*NUM_BANKS-1:0] bankMode,
  output logic [NUM_BANKS-1:0]   errFlag,
  output logic                   rdInvalid
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int OFF_W  = ADDR_W - BANK_W;

  logic [BANK_W-1:0] wrBank, rdBank;
  logic [SECT_W-1:0] wrSector, rdSector;
  bankState_t        stArr [NUM_BANKS];
  logic [SECT_W-1:0] secArr [NUM_BANKS];
  logic              wholeArr [NUM_BANKS];

  assign wrBank   = wrAddr[ADDR_W-1 -: BANK_W];
  assign rdBank   = rdAddr[ADDR_W-1 -: BANK_W];
  assign wrSector = wrAddr[OFF_W-1 -: SECT_W];
  assign rdSector = rdAddr[OFF_W-1 -: SECT_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitB;
    assign hitB = wr.valid && (wrBank == BANK_W'(b));

    fcmd_bank_fsm #(.SECT_W(SECT_W)) u_fsm (
      .clk       (clk),
      .rstN      (rstN),
      .wr        (wr),
      .hit       (hitB),
      .wrSector  (wrSector),
      .engDone   (engDone[b]),
      .engErr    (engErr[b]),
      .state     (stArr[b]),
      .engStart  (engStart[b]),
      .engOp     (engOp[2*b +: 2]),
      .suspSector(secArr[b]),
      .suspWhole (wholeArr[b])
    );

    assign bankMode[4*b +: 4] = modeOf(stArr[b]);
    assign errFlag[b]         = (stArr[b] == S_ERROR);
  end

  always_comb begin
    rdInvalid = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdBank == BANK_W'(b) && stArr[b] == S_SREAD &&
          (wholeArr[b] || secArr[b] == rdSector))
        rdInvalid = 1'b1;
    end
  end

endmodule

// File: rtl/fcmd_iface.sv
module fcmd_iface
  import fcmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   weN,
  input  logic                   ceN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             data,
  input  logic [NUM_BANKS-1:0]   engDone,
  input  logic [NUM_BANKS-1:0]   engErr,
  output logic [NUM_BANKS-1:0]   engStart,
  output logic [2*NUM_BANKS-1:0] engOp,
  output logic [4*NUM_BANKS-1:0] bankMode,
  output logic [NUM_BANKS-1:0]   errFlag,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic                   rdInvalid
);

  hostWrite_t        wrEvt;
  logic [ADDR_W-1:0] wrAddr;

  fcmd_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk   (clk),
    .rstN  (rstN),
    .weN   (weN),
    .ceN   (ceN),
    .addr  (addr),
    .data  (data),
    .wrOut (wrEvt),
    .wrAddr(wrAddr)
  );

  fcmd_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wr       (wrEvt),
    .wrAddr   (wrAddr),
    .engDone  (engDone),
    .engErr   (engErr),
    .rdAddr   (rdAddr),
    .engStart (engStart),
    .engOp    (engOp),
    .bankMode (bankMode),
    .errFlag  (errFlag),
    .rdInvalid(rdInvalid)
  );

endmodule

// File: rtl/fcmd_iface_chk.sv
module fcmd_iface_chk
  import fcmd_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_BANKS-1:0]   engDone,
  input logic [NUM_BANKS-1:0]   engErr,
  input logic [NUM_BANKS-1:0]   engStart,
  input logic [4*NUM_BANKS-1:0] bankMode,
  input logic [NUM_BANKS-1:0]   errFlag,
  input logic [ADDR_W-1:0]      rdAddr,
  input logic                   rdInvalid
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0] rdBank;
  logic [3:0]        rdMode;
  assign rdBank = rdAddr[ADDR_W-1 -: BANK_W];

  always_comb begin
    rdMode = MODE_READ;
    for (int b = 0; b < NUM_BANKS; b++)
      if (rdBank == BANK_W'(b)) rdMode = bankMode[4*b +: 4];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (bankMode[4*b +: 4] == MODE_BPROG && !engDone[b] && !engErr[b])
        |=> bankMode[4*b +: 4] == MODE_BPROG);

    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
      engStart[b] |-> (bankMode[4*b +: 4] == MODE_BPROG ||
                       bankMode[4*b +: 4] == MODE_BERASE));

    p_err_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
      (bankMode[4*b +: 4] == MODE_BERASE && engErr[b]) |=> errFlag[b]);

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errFlag[b]) |-> $past(engErr[b]));
  end

  p_rd_invalid_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdInvalid |-> rdMode == MODE_SREAD);

endmodule

bind fcmd_iface fcmd_iface_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .engDone  (engDone),
  .engErr   (engErr),
  .engStart (engStart),
  .bankMode (bankMode),
  .errFlag  (errFlag),
  .rdAddr   (rdAddr),
  .rdInvalid(rdInvalid)
);

// File: tb/fcmd_iface_tb.sv
`timescale 1ns/1ps
module fcmd_iface_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        weN = 1'b1, ceN = 1'b1;
  logic [15:0] addr = '0, rdAddr = '0;
  logic [7:0]  data = '0;
  logic [1:0]  engDone = '0, engErr = '0;
  logic [1:0]  engStart, errFlag;
  logic [3:0]  engOp;
  logic [7:0]  bankMode;
  logic        rdInvalid;

  int checks = 0, failures = 0;
  int startCnt [2];
  int lastOp [2];
  bit finished = 0;

  always #2 clk = ~clk;

  fcmd_iface u_dut (
    .clk(clk), .rstN(rstN), .weN(weN), .ceN(ceN), .addr(addr), .data(data),
    .engDone(engDone), .engErr(engErr), .engStart(engStart), .engOp(engOp),
    .bankMode(bankMode), .errFlag(errFlag), .rdAddr(rdAddr), .rdInvalid(rdInvalid)
  );

  initial begin
    startCnt[0] = 0; startCnt[1] = 0; lastOp[0] = -1; lastOp[1] = -1;
  end

  always @(negedge clk) begin
    for (int b = 0; b < 2; b++)
      if (engStart[b]) begin
        startCnt[b] = startCnt[b] + 1;
        lastOp[b]   = int'(engOp[2*b +: 2]);
      end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; addr = a; data = d;
    repeat (2) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic keys(input logic [15:0] bankBase);
    wr(bankBase | 16'h0555, 8'hAA);
    wr(bankBase | 16'h02AA, 8'h55);
  endtask

  task automatic pulse(input int b, input bit isErr);
    @(negedge clk);
    if (isErr) engErr[b] = 1'b1; else engDone[b] = 1'b1;
    @(negedge clk);
    engErr = '0; engDone = '0;
    @(negedge clk);
  endtask

  function automatic int md(input int b);
    return int'(bankMode[4*b +: 4]);
  endfunction

  // {addr, data, expected mode bank0, expected mode bank1}
  localparam logic [31:0] VEC [21] = '{
    {16'h0555, 8'hAA, 4'd3, 4'd0},  // R3 key 1
    {16'h02AA, 8'h55, 4'd3, 4'd0},  // R3 key 2
    {16'h0555, 8'h90, 4'd2, 4'd0},  // R3 identification
    {16'h0123, 8'hA0, 4'd2, 4'd0},  // R3 ignored there
    {16'h0000, 8'hF0, 4'd0, 4'd0},  // R3 reset out
    {16'h8555, 8'hAA, 4'd0, 4'd3},  // R12 bank 1 only
    {16'h0555, 8'hAA, 4'd3, 4'd3},  // R12 interleaved
    {16'h82AA, 8'h55, 4'd3, 4'd3},
    {16'h02AA, 8'h55, 4'd3, 4'd3},
    {16'h8555, 8'h80, 4'd3, 4'd4},  // R5 erase setup
    {16'h87FF, 8'hF0, 4'd3, 4'd0},  // R6 abort erase sequence
    {16'h0555, 8'hA0, 4'd3, 4'd0},  // R4 program setup
    {16'h0ABC, 8'hF0, 4'd0, 4'd0},  // R6 abort program sequence
    {16'h0555, 8'hAA, 4'd3, 4'd0},
    {16'h0333, 8'h55, 4'd8, 4'd0},  // R11 wrong key address
    {16'h0555, 8'hAA, 4'd8, 4'd0},  // R11 stays invalid
    {16'h0000, 8'hF0, 4'd0, 4'd0},  // R11 reset recovers
    {16'h8123, 8'h77, 4'd0, 4'd8},  // R11 stray write
    {16'h8000, 8'hF0, 4'd0, 4'd0},
    {16'h0555, 8'hB0, 4'd8, 4'd0},  // R11 suspend out of place
    {16'h0000, 8'hF0, 4'd0, 4'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bank0 mode", md(0), 0);
    chk("R1 bank1 mode", md(1), 0);
    chk("R1 errFlag", int'(errFlag), 0);
    chk("R1 no start", startCnt[0] + startCnt[1], 0);

    for (int i = 0; i < 21; i++) begin
      wr(VEC[i][31:16], VEC[i][15:8]);
      chk($sformatf("R3/R6/R11/R12 vec%0d bank0", i), md(0), int'(VEC[i][7:4]));
      chk($sformatf("R3/R6/R11/R12 vec%0d bank1", i), md(1), int'(VEC[i][3:0]));
    end

    // R2 capture points
    @(negedge clk); ceN = 1'b0; addr = 16'h0123; data = 8'h00;
    repeat (2) @(negedge clk); weN = 1'b0; addr = 16'h0555; data = 8'h11;
    repeat (2) @(negedge clk); addr = 16'h0777; data = 8'hAA;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); data = 8'h00; ceN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 capture later fall/first rise", md(0), 3);
    wr(16'h0000, 8'hF0);

    // R4 program
    keys(16'h0000); wr(16'h0555, 8'hA0);
    chk("R4 program setup", md(0), 3);
    wr(16'h0040, 8'h5A);
    chk("R4 busy program", md(0), 5);
    chk("R4 start count", startCnt[0], 1);
    chk("R4 op program", lastOp[0], 0);
    wr(16'h0000, 8'hF0);
    chk("R7 reset ignored busy program", md(0), 5);
    pulse(0, 0);
    chk("R4 done to read", md(0), 0);

    // R5 sector erase of sector 5 in bank 0
    keys(16'h0000); wr(16'h0555, 8'h80);
    chk("R5 erase setup", md(0), 4);
    keys(16'h0000); wr(16'h5000, 8'h30);
    chk("R5 busy erase", md(0), 6);
    chk("R5 op sector", lastOp[0], 1);
    wr(16'h0000, 8'hF0);
    chk("R7 reset ignored busy erase", md(0), 6);
    keys(16'h8000); wr(16'h8555, 8'h90);
    chk("R12 bank1 decodes while bank0 busy", md(1), 2);
    wr(16'h8000, 8'hF0);
    wr(16'h0000, 8'hB0);
    chk("R8 suspend", md(0), 1);
    rdAddr = 16'h5004; #1 chk("R8 suspended sector invalid", int'(rdInvalid), 1);
    rdAddr = 16'h1000; #1 chk("R8 other sector valid", int'(rdInvalid), 0);
    rdAddr = 16'hD000; #1 chk("R8 other bank valid", int'(rdInvalid), 0);
    // R9 program from suspension
    keys(16'h0000); wr(16'h0555, 8'hA0); wr(16'h1100, 8'h12);
    chk("R9 busy program in suspend", md(0), 5);
    pulse(0, 0);
    chk("R9 program done to suspend-read", md(0), 1);
    keys(16'h0000); wr(16'h0555, 8'h90); wr(16'h0000, 8'hF0);
    chk("R9 identification reset to suspend-read", md(0), 1);
    keys(16'h0000); wr(16'h0ABC, 8'hF0);
    chk("R9 sequence reset to suspend-read", md(0), 1);
    keys(16'h0000); wr(16'h0555, 8'h80);
    chk("R11 erase setup in suspend invalid", md(0), 8);
    wr(16'h0000, 8'hF0);
    chk("R9 invalid reset to suspend-read", md(0), 1);
    wr(16'h0000, 8'h30);
    chk("R8 resume", md(0), 6);
    chk("R8 op resume", lastOp[0], 3);
    pulse(0, 1);
    chk("R10 error mode", md(0), 7);
    chk("R10 errFlag", int'(errFlag[0]), 1);
    wr(16'h0555, 8'hAA);
    chk("R10 error holds", md(0), 7);
    wr(16'h0000, 8'hF0);
    chk("R10 reset to read", md(0), 0);
    chk("R10 errFlag clear", int'(errFlag[0]), 0);

    // bank erase on bank 1
    keys(16'h8000); wr(16'h8555, 8'h80); keys(16'h8000); wr(16'h8555, 8'h10);
    chk("R5 op bank erase", lastOp[1], 2);
    chk("R5 bank erase busy", md(1), 6);
    wr(16'h8000, 8'hB0);
    rdAddr = 16'h8000; #1 chk("R8 whole bank invalid low", int'(rdInvalid), 1);
    rdAddr = 16'hF000; #1 chk("R8 whole bank invalid high", int'(rdInvalid), 1);
    keys(16'h8000); wr(16'h8555, 8'hA0); wr(16'h8100, 8'h00);
    pulse(1, 1);
    chk("R10 error from suspended program", md(1), 7);
    wr(16'h8000, 8'hF0);
    chk("R10 reset to suspend-read", md(1), 1);
    wr(16'h8000, 8'h30);
    pulse(1, 0);
    chk("R5 erase done to read", md(1), 0);
    chk("R12 bank0 untouched", md(0), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule